// File: doc/BRIEF.md
# Four-Register ALU Datapath with Shared Bus

This block is an 8-bit datapath slice. It holds four general registers, a function unit with 16 arithmetic and 16 logic operations, a carry flag and one shared data bus. Every value that enters a register arrives over that bus. The value comes from one of two sources: an 8-bit switch input, or the function unit's result.

The destination select has two jobs. It names the register that a write will load, and it supplies operand A to the function unit. The source select supplies operand B. An external controller sets the mode, function code and active-low carry input, then chooses which bus driver is enabled and whether the destination register loads the bus on the next rising clock edge. Because the destination register is also operand A, an operation such as "A plus B into A" takes a single clock. The function unit is built from 4-bit slices chained through their carries.

Top module: `regbus_datapath`

## Requirements
- R1: After reset, all four registers read 0 and `carry_flag` is 0. Reset is asserted asynchronously and is released only on the second rising clock edge after `rst_n` goes high.
- R2: When `wr_en` is 1, the register named by `sel_dst` loads `bus_out` on the rising edge of `clk`. The other registers keep their values.
- R3: When `sw_to_bus` is 1 and `alu_to_bus` is 0, `bus_out` equals `sw_data`.
- R4: When both drivers are disabled, `bus_out` is 0. When both are enabled, `bus_out` is the bitwise OR of `sw_data` and the function result.
- R5: With `mode_logic`=0 and `func`=4'b1001, the result is A+B when `cin_n`=1 and A+B+1 when `cin_n`=0. All results are modulo 256.
- R6: With `mode_logic`=0 and `func`=4'b0110, the result is A-B-1 when `cin_n`=1 and A-B when `cin_n`=0.
- R7: With `mode_logic`=1, each code gives the following result: 4'b1011 gives A AND B, 4'b0000 gives NOT A, 4'b1010 gives B, and 4'b1111 gives A.
- R8: In logic mode, `cin_n` has no effect, and the full code set is as follows. 0011 gives all zeros and 1100 gives all ones. 0101 gives NOT B. 0110 gives A XOR B and 1001 gives its complement. 1110 gives A OR B and 0001 gives NOR. 0100 gives NAND. 0010 gives (NOT A) AND B, and 0111 gives A AND (NOT B). 1000 gives (NOT A) OR B, and 1101 gives A OR (NOT B). Codes 0000, 1010, 1011 and 1111 behave as stated in R7.
- R9: In arithmetic mode, the result is X+Y plus 1 when `cin_n`=0, where X and Y depend on `func` as follows. 0000: X=A, Y=0. 0001: X=A|B, Y=0. 0010: X=A|~B, Y=0. 0011: X=FF, Y=0. 0100: X=A, Y=A&~B. 0101: X=A|B, Y=A&~B. 0110: X=A, Y=~B. 0111: X=A&~B, Y=FF. 1000: X=A, Y=A&B. 1001: X=A, Y=B. 1010: X=A|~B, Y=A&B. 1011: X=A&B, Y=FF. 1100: X=A, Y=A. 1101: X=A|B, Y=A. 1110: X=A|~B, Y=A. 1111: X=A, Y=FF.
- R10: When `carry_ld` is 1, `carry_flag` loads bit 8 of the arithmetic sum of R9 (carry-in included) on the rising clock edge. When `carry_ld` is 0, `carry_flag` holds its value.
- R11: Operand A is the register named by `sel_dst` and operand B is the register named by `sel_src`. Both selects may name the same register.
- R12: When `wr_en` is 0, no register changes, whatever the bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers and carry flag update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_data | input | 8 | Switch data offered to the bus |
| sel_dst | input | 2 | Register to write; also the operand A select |
| sel_src | input | 2 | Operand B select |
| wr_en | input | 1 | Destination register loads the bus when 1 |
| sw_to_bus | input | 1 | Enables the switch driver onto the bus |
| alu_to_bus | input | 1 | Enables the function-unit driver onto the bus |
| mode_logic | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| func | input | 4 | Function code |
| cin_n | input | 1 | Active-low carry input |
| carry_ld | input | 1 | Loads the carry flag when 1 |
| bus_out | output | 8 | Shared data bus |
| carry_flag | output | 1 | Latched carry |

## Verification
The bench uses the default parameters: 8-bit data, 4-bit slices and four registers. This puts the carry chain between the two slices within reach, along with the carry out of bit 7 into the flag and every select value of both register ports. Random operands run through all 32 function codes with both carry-in values. Directed cases cover the carry across the slice boundary (0F+01), full overflow (FF+01), the same register used as both operands, and results written back through the bus.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FUNC_W = 4;

  typedef struct packed {
    logic              logic_mode;
    logic [FUNC_W-1:0] func;
  } alu_ctrl_t;
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      stage2 <= stage1;
    end
  end

  assign rst_core_n = stage2;
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [SEL_W-1:0]  rd_b_sel,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] file_q  [NREG];
  logic [DATA_W-1:0] file_nx [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      file_nx[i] = file_q[i];
    end
    if (wr_en) begin
      file_nx[wr_sel] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        file_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        file_q[i] <= file_nx[i];
      end
    end
  end

  assign rd_a = file_q[rd_a_sel];
  assign rd_b = file_q[rd_b_sel];
endmodule

// File: rtl/dp_alu_slice.sv
module dp_alu_slice
  import dp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctrl_t    ctrl,
  input  logic         c_in,
  output logic [W-1:0] f,
  output logic         c_out
);
  logic [W-1:0] term_p;
  logic [W-1:0] term_g;
  logic [W:0]   sum;

  always_comb begin
    term_p = a | (b & {W{ctrl.func[0]}}) | (~b & {W{ctrl.func[1]}});
    term_g = (a & ~b & {W{ctrl.func[2]}}) | (a & b & {W{ctrl.func[3]}});
    sum    = {1'b0, term_p} + {1'b0, term_g} + {{W{1'b0}}, c_in};
    if (ctrl.logic_mode) begin
      f = ~(term_p ^ term_g);
    end else begin
      f = sum[W-1:0];
    end
    c_out = sum[W];
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4,
  localparam int NSLICE = DATA_W / SLICE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_ctrl_t         ctrl,
  input  logic              c_in,
  output logic [DATA_W-1:0] f,
  output logic              c_out
);
  logic [NSLICE:0] chain;

  assign chain[0] = c_in;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    dp_alu_slice #(.W(SLICE_W)) i_slice (
      .a     (a[g*SLICE_W +: SLICE_W]),
      .b     (b[g*SLICE_W +: SLICE_W]),
      .ctrl  (ctrl),
      .c_in  (chain[g]),
      .f     (f[g*SLICE_W +: SLICE_W]),
      .c_out (chain[g+1])
    );
  end

  assign c_out = chain[NSLICE];
endmodule

// File: rtl/dp_bus_merge.sv
module dp_bus_merge #(
  parameter int W = 8
) (
  input  logic         sw_en,
  input  logic [W-1:0] sw_val,
  input  logic         alu_en,
  input  logic [W-1:0] alu_val,
  output logic [W-1:0] bus
);
  assign bus = ({W{sw_en}} & sw_val) | ({W{alu_en}} & alu_val);
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4,
  parameter int NREG    = 4,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sw_data,
  input  logic [SEL_W-1:0]  sel_dst,
  input  logic [SEL_W-1:0]  sel_src,
  input  logic              wr_en,
  input  logic              sw_to_bus,
  input  logic              alu_to_bus,
  input  logic              mode_logic,
  input  logic [FUNC_W-1:0] func,
  input  logic              cin_n,
  input  logic              carry_ld,
  output logic [DATA_W-1:0] bus_out,
  output logic              carry_flag
);
  logic              rst_core_n;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_f;
  logic              alu_cout;
  logic              carry_nx;
  alu_ctrl_t         ctrl;

  assign ctrl.logic_mode = mode_logic;
  assign ctrl.func       = func;

  dp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  dp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) i_regfile (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_sel   (sel_dst),
    .wr_data  (bus_out),
    .rd_a_sel (sel_dst),
    .rd_b_sel (sel_src),
    .rd_a     (opa),
    .rd_b     (opb)
  );

  dp_alu #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_alu (
    .a     (opa),
    .b     (opb),
    .ctrl  (ctrl),
    .c_in  (~cin_n),
    .f     (alu_f),
    .c_out (alu_cout)
  );

  dp_bus_merge #(.W(DATA_W)) i_bus (
    .sw_en   (sw_to_bus),
    .sw_val  (sw_data),
    .alu_en  (alu_to_bus),
    .alu_val (alu_f),
    .bus     (bus_out)
  );

  always_comb begin
    carry_nx = carry_flag;
    if (carry_ld) begin
      carry_nx = alu_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      carry_flag <= 1'b0;
    end else begin
      carry_flag <= carry_nx;
    end
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic              sw_to_bus,
  input logic              alu_to_bus,
  input logic              mode_logic,
  input logic [3:0]        func,
  input logic              cin_n,
  input logic              carry_ld,
  input logic [SEL_W-1:0]  sel_dst,
  input logic [DATA_W-1:0] sw_data,
  input logic [DATA_W-1:0] bus_out,
  input logic              carry_flag,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb
);
  AST_BUS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_to_bus && !alu_to_bus) |-> (bus_out == sw_data)); // R3

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_to_bus && !alu_to_bus) |-> (bus_out == '0)); // R4

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_to_bus && !sw_to_bus && !mode_logic && func == 4'b1001)
      |-> (bus_out == DATA_W'(opa + opb + {{(DATA_W-1){1'b0}}, !cin_n}))); // R5

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rst_core_n) |=> (!$stable(sel_dst) || opa == $past(bus_out))); // R2

  AST_NOWRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rst_core_n) |=> (!$stable(sel_dst) || $stable(opa))); // R12

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_ld && rst_core_n) |=> $stable(carry_flag)); // R10

  AST_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_core_n) |=> (carry_flag == 1'b0 && opa == '0 && opb == '0)); // R1
endmodule

bind regbus_datapath dp_checker i_chk (.*);

// File: tb/test_regbus_datapath.sv
module test_regbus_datapath;
  logic       clk;
  logic       rst_n;
  logic [7:0] sw_data;
  logic [1:0] sel_dst;
  logic [1:0] sel_src;
  logic       wr_en;
  logic       sw_to_bus;
  logic       alu_to_bus;
  logic       mode_logic;
  logic [3:0] func;
  logic       cin_n;
  logic       carry_ld;
  logic [7:0] bus_out;
  logic       carry_flag;

  int total = 0;
  int bad   = 0;

  regbus_datapath i_regbus_datapath (
    .clk(clk), .rst_n(rst_n), .sw_data(sw_data), .sel_dst(sel_dst),
    .sel_src(sel_src), .wr_en(wr_en), .sw_to_bus(sw_to_bus),
    .alu_to_bus(alu_to_bus), .mode_logic(mode_logic), .func(func),
    .cin_n(cin_n), .carry_ld(carry_ld), .bus_out(bus_out),
    .carry_flag(carry_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ref_calc(input logic lm, input logic [3:0] s,
                                          input logic cn, input logic [7:0] a,
                                          input logic [7:0] b);
    logic [8:0] x;
    logic [8:0] y;
    logic [7:0] r;
    if (lm) begin
      case (s)
        4'b0000: r = ~a;
        4'b0001: r = ~(a | b);
        4'b0010: r = ~a & b;
        4'b0011: r = 8'h00;
        4'b0100: r = ~(a & b);
        4'b0101: r = ~b;
        4'b0110: r = a ^ b;
        4'b0111: r = a & ~b;
        4'b1000: r = ~a | b;
        4'b1001: r = ~(a ^ b);
        4'b1010: r = b;
        4'b1011: r = a & b;
        4'b1100: r = 8'hFF;
        4'b1101: r = a | ~b;
        4'b1110: r = a | b;
        default: r = a;
      endcase
      return {1'b0, r};
    end
    case (s)
      4'b0000: begin x = {1'b0, a};      y = 9'h000;          end
      4'b0001: begin x = {1'b0, a | b};  y = 9'h000;          end
      4'b0010: begin x = {1'b0, a | ~b}; y = 9'h000;          end
      4'b0011: begin x = 9'h0FF;         y = 9'h000;          end
      4'b0100: begin x = {1'b0, a};      y = {1'b0, a & ~b};  end
      4'b0101: begin x = {1'b0, a | b};  y = {1'b0, a & ~b};  end
      4'b0110: begin x = {1'b0, a};      y = {1'b0, ~b};      end
      4'b0111: begin x = {1'b0, a & ~b}; y = 9'h0FF;          end
      4'b1000: begin x = {1'b0, a};      y = {1'b0, a & b};   end
      4'b1001: begin x = {1'b0, a};      y = {1'b0, b};       end
      4'b1010: begin x = {1'b0, a | ~b}; y = {1'b0, a & b};   end
      4'b1011: begin x = {1'b0, a & b};  y = 9'h0FF;          end
      4'b1100: begin x = {1'b0, a};      y = {1'b0, a};       end
      4'b1101: begin x = {1'b0, a | b};  y = {1'b0, a};       end
      4'b1110: begin x = {1'b0, a | ~b}; y = {1'b0, a};       end
      default: begin x = {1'b0, a};      y = 9'h0FF;          end
    endcase
    return x + y + {8'h00, ~cn};
  endfunction

  task automatic idle_inputs();
    wr_en = 1'b0; sw_to_bus = 1'b0; alu_to_bus = 1'b0; carry_ld = 1'b0;
  endtask

  task automatic write_sw(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    idle_inputs();
    sel_dst = idx; sw_data = val; sw_to_bus = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic read_reg(input logic [1:0] idx, output logic [7:0] val);
    idle_inputs();
    sel_dst = idx; mode_logic = 1'b1; func = 4'b1111; alu_to_bus = 1'b1;
    #1 val = bus_out;
    alu_to_bus = 1'b0;
  endtask

  task automatic apply_op(input logic lm, input logic [3:0] s, input logic cn,
                          input logic [1:0] d, input logic [1:0] src);
    idle_inputs();
    mode_logic = lm; func = s; cin_n = cn; sel_dst = d; sel_src = src;
    alu_to_bus = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      read_reg(2'(i), v);
      chk("R1 register cleared", {1'b0, v}, 9'h000);
    end
    chk("R1 carry cleared", {8'h00, carry_flag}, 9'h000);
  endtask

  task automatic t_bus();
    @(negedge clk);
    idle_inputs();
    sw_data = 8'h5A; sw_to_bus = 1'b1;
    #1 chk("R3 switch drives bus", {1'b0, bus_out}, 9'h05A);
    sw_to_bus = 1'b0;
    #1 chk("R4 idle bus is zero", {1'b0, bus_out}, 9'h000);
    write_sw(2'd1, 8'h30);
    @(negedge clk);
    apply_op(1'b1, 4'b1111, 1'b1, 2'd1, 2'd0);
    sw_data = 8'h03; sw_to_bus = 1'b1;
    #1 chk("R4 both drivers OR", {1'b0, bus_out}, 9'h033);
    idle_inputs();
  endtask

  task automatic t_write();
    logic [7:0] v;
    write_sw(2'd0, 8'h55);
    write_sw(2'd1, 8'hAA);
    write_sw(2'd2, 8'h03);
    write_sw(2'd3, 8'h04);
    read_reg(2'd0, v); chk("R2 write R0", {1'b0, v}, 9'h055);
    read_reg(2'd1, v); chk("R2 write R1", {1'b0, v}, 9'h0AA);
    read_reg(2'd2, v); chk("R2 write R2", {1'b0, v}, 9'h003);
    read_reg(2'd3, v); chk("R2 write R3", {1'b0, v}, 9'h004);
    apply_op(1'b1, 4'b1010, 1'b1, 2'd0, 2'd3);
    chk("R11 operand B from sel_src", {1'b0, bus_out}, 9'h004);
    @(negedge clk);
    idle_inputs();
    sel_dst = 2'd2; sw_data = 8'hEE; sw_to_bus = 1'b1;
    @(negedge clk);
    read_reg(2'd2, v); chk("R12 no write when disabled", {1'b0, v}, 9'h003);
  endtask

  task automatic t_arith();
    logic [7:0] v;
    write_sw(2'd0, 8'h07);
    write_sw(2'd1, 8'h01);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd0, 2'd1);
    chk("R5 add no carry", {1'b0, bus_out}, 9'h008);
    apply_op(1'b0, 4'b1001, 1'b0, 2'd0, 2'd1);
    chk("R5 add with carry", {1'b0, bus_out}, 9'h009);
    apply_op(1'b0, 4'b0110, 1'b1, 2'd0, 2'd1);
    chk("R6 sub minus one", {1'b0, bus_out}, 9'h005);
    apply_op(1'b0, 4'b0110, 1'b0, 2'd0, 2'd1);
    chk("R6 sub", {1'b0, bus_out}, 9'h006);
    // write back R0 <= R0 + R1 twice through the bus
    @(negedge clk);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd0, 2'd1);
    wr_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    idle_inputs();
    read_reg(2'd0, v); chk("R2 ALU write back", {1'b0, v}, 9'h009);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd2, 2'd2);
    write_sw(2'd2, 8'h21);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd2, 2'd2);
    chk("R11 same register both operands", {1'b0, bus_out}, 9'h042);
  endtask

  task automatic t_logic();
    write_sw(2'd0, 8'h07);
    write_sw(2'd1, 8'h09);
    apply_op(1'b1, 4'b1011, 1'b1, 2'd0, 2'd1);
    chk("R7 AND", {1'b0, bus_out}, 9'h001);
    apply_op(1'b1, 4'b0000, 1'b1, 2'd0, 2'd1);
    chk("R7 NOT A", {1'b0, bus_out}, 9'h0F8);
    apply_op(1'b1, 4'b1010, 1'b0, 2'd0, 2'd1);
    chk("R7 pass B", {1'b0, bus_out}, 9'h009);
    apply_op(1'b1, 4'b0110, 1'b0, 2'd0, 2'd1);
    chk("R8 XOR ignores cin_n", {1'b0, bus_out}, 9'h00E);
  endtask

  task automatic t_sweep();
    logic [7:0] a;
    logic [7:0] b;
    logic [8:0] e;
    for (int p = 0; p < 6; p++) begin
      a = (p == 0) ? 8'hFF : 8'($urandom);
      b = (p == 0) ? 8'h01 : 8'($urandom);
      write_sw(2'd2, a);
      write_sw(2'd3, b);
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 16; s++) begin
          for (int c = 0; c < 2; c++) begin
            apply_op(m[0], 4'(s), c[0], 2'd2, 2'd3);
            e = ref_calc(m[0], 4'(s), c[0], a, b);
            if (m == 1) chk("R8 logic function", {1'b0, bus_out}, {1'b0, e[7:0]});
            else        chk("R9 arithmetic function", {1'b0, bus_out}, {1'b0, e[7:0]});
          end
        end
      end
    end
  endtask

  task automatic t_carry();
    write_sw(2'd0, 8'hFF);
    write_sw(2'd1, 8'h01);
    write_sw(2'd2, 8'h0F);
    @(negedge clk);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd0, 2'd1);
    carry_ld = 1'b1;
    @(negedge clk);
    carry_ld = 1'b0;
    #1 chk("R10 carry from FF+01", {8'h00, carry_flag}, 9'h001);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd2, 2'd1);
    chk("R9 carry across slices", {1'b0, bus_out}, 9'h010);
    @(negedge clk);
    @(negedge clk);
    #1 chk("R10 carry held", {8'h00, carry_flag}, 9'h001);
    apply_op(1'b0, 4'b1001, 1'b1, 2'd2, 2'd1);
    carry_ld = 1'b1;
    @(negedge clk);
    carry_ld = 1'b0;
    #1 chk("R10 carry cleared by 0F+01", {8'h00, carry_flag}, 9'h000);
    apply_op(1'b0, 4'b0110, 1'b0, 2'd0, 2'd1);
    carry_ld = 1'b1;
    @(negedge clk);
    carry_ld = 1'b0;
    #1 chk("R10 carry from FF-01", {8'h00, carry_flag}, 9'h001);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_data = '0; sel_dst = '0; sel_src = '0; mode_logic = 1'b0;
    func = '0; cin_n = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bus();
    t_write();
    t_arith();
    t_logic();
    t_sweep();
    t_carry();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule